// File: doc/BRIEF.md
# Transmit Queue Launch Controller

This block sits between the host-facing message store and a serial frame engine on a CAN-style controller. The host pushes tagged messages into an eight-deep queue. The block decides when the oldest message is handed to the frame engine. It then reacts to the result the engine reports: success, lost arbitration or a bus error.

The launch request is the OR of an external enable pin, a continuous-send control bit and a single-message control bit. The pin and the continuous bit drain the queue back to back. The single-message bit releases one message each time it is raised. After a failed attempt the head message is normally relaunched. If one-shot and single-message are both set, the failed message is dropped instead.

The host can empty the queue or abort the attempt in flight. Each successful send records the message tag and a 16-bit time stamp in a history queue, which the host reads back one entry per read pulse. The time stamp comes from a free-running counter that advances every 1, 2, 4 or 8 clocks.

Top module: `txq_launch_ctrl`

## Requirements
- R1: The message queue holds at most QDEPTH (default 8) entries. A write pulse while the queue is full is ignored. `q_count` reports the current number of queued messages one cycle after any change.
- R2: Messages are launched in write order. While `eng_start` is high, `eng_tag`/`eng_data` present the oldest queued message.
- R3: A launch drives `eng_start` high for one cycle, in the cycle after the clock edge on which it was decided. While `pin_txen` or `cfg_cont` is high, queued messages are launched one after another until the queue is empty, each once the previous one has completed.
- R4: With `pin_txen` and `cfg_cont` low, `cfg_single` launches exactly one message per low-to-high transition. A level held high launches no second message. After reset the first high level counts as a transition.
- R5: With `pin_txen`, `cfg_cont` and `cfg_single` all low, no message is launched and the queue contents stay in place.
- R6: A failure result (`eng_arb_lost` or `eng_error` without `eng_done_ok`) while `cfg_oneshot` and `cfg_single` are both high removes the head message. It causes no relaunch and no history entry.
- R7: A failure result in any other configuration keeps the head message and drives `eng_start` again in the next cycle.
- R8: `cmd_abort` during an attempt in flight removes the head message, writes no history entry and pulses `eng_abort` for one cycle. With no attempt in flight it has no effect.
- R9: `cmd_clear` empties the queue (`q_count` reads 0 the next cycle) and ignores a write in the same cycle. If an attempt is in flight it also pulses `eng_abort`. It takes priority over abort and results.
- R10: `eng_done_ok` during an attempt removes the head message and appends {tag, time stamp} to the history queue. The entry is dropped if the history queue already holds HDEPTH (default 8) entries. `hist_valid` flags a non-empty history, `hist_tag`/`hist_stamp` show its oldest entry, and `hist_rd` removes it.
- R11: The stored time stamp is the count of prescaler ticks since reset, modulo 2^16. A 3-bit prescaler counts every clock, and a tick occurs when its low `tt_div` bits are all ones. `tt_div` 0/1/2/3 therefore gives divide by 1/2/4/8.
- R12: After reset the queue and history are empty, `eng_start` and `eng_abort` are low and the time stamp is 0.
- R13: Result inputs arriving while no attempt is in flight are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write pulse, queue a message |
| wr_tag | input | TAG_W | Host tag of the message |
| wr_data | input | DATA_W | Message body |
| pin_txen | input | 1 | External transmit enable pin |
| cfg_cont | input | 1 | Continuous send enable |
| cfg_single | input | 1 | Single-message send request |
| cfg_oneshot | input | 1 | No-retry option (with cfg_single) |
| cmd_clear | input | 1 | Empty the queue |
| cmd_abort | input | 1 | Abort attempt in flight |
| tt_div | input | 2 | Time stamp prescaler select |
| eng_done_ok | input | 1 | Engine: sent successfully |
| eng_arb_lost | input | 1 | Engine: arbitration lost |
| eng_error | input | 1 | Engine: bus error |
| eng_start | output | 1 | Start pulse to engine |
| eng_abort | output | 1 | Abort pulse to engine |
| eng_tag | output | TAG_W | Head message tag |
| eng_data | output | DATA_W | Head message body |
| q_count | output | clog2(QDEPTH)+1 | Queued message count |
| hist_rd | input | 1 | Pop oldest history entry |
| hist_valid | output | 1 | History not empty |
| hist_tag | output | TAG_W | Oldest history tag |
| hist_stamp | output | TS_W | Oldest history time stamp |

## Verification
A wrong launch state, such as a lost single-send arm flag or a stuck in-flight flag, shows at `eng_start` within one cycle of the next launch opportunity. A read pointer that slips shows up the next time `eng_tag` or `hist_tag` differs from the write order. Miscounting shows at `q_count` in the cycle after the faulty update. A wrong prescaler or a history push taken on the wrong result stays hidden until the next history entry, whose stamp or mere presence then differs from the expected value.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic {
    TXQ_IDLE = 1'b0,
    TXQ_WAIT = 1'b1
  } txq_state_e;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr_ok, rd_ok;

  assign wr_ok   = wr_en && (count != CW'(DEPTH));
  assign rd_ok   = rd_en && (count != '0);
  assign rd_data = mem[rptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + AW'(1);
      if (rd_ok) rptr <= rptr + AW'(1);
      count <= count + CW'(wr_ok) - CW'(rd_ok);
    end
  end
endmodule

// File: rtl/txq_timetag.sv
module txq_timetag #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      tt_div,
  output logic [TS_W-1:0] stamp
);
  logic [2:0] pre;
  logic [2:0] mask;
  logic       tick;

  assign mask = 3'((4'd1 << tt_div) - 4'd1);
  assign tick = (pre & mask) == mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre   <= '0;
      stamp <= '0;
    end else begin
      pre <= pre + 3'd1;
      if (tick) stamp <= stamp + TS_W'(1);
    end
  end
endmodule

// File: rtl/txq_launch_ctrl.sv
module txq_launch_ctrl
  import txq_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 64,
  parameter int QDEPTH = 8,
  parameter int HDEPTH = 8,
  parameter int TS_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_valid,
  input  logic [TAG_W-1:0]          wr_tag,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      pin_txen,
  input  logic                      cfg_cont,
  input  logic                      cfg_single,
  input  logic                      cfg_oneshot,
  input  logic                      cmd_clear,
  input  logic                      cmd_abort,
  input  logic [1:0]                tt_div,
  input  logic                      eng_done_ok,
  input  logic                      eng_arb_lost,
  input  logic                      eng_error,
  output logic                      eng_start,
  output logic                      eng_abort,
  output logic [TAG_W-1:0]          eng_tag,
  output logic [DATA_W-1:0]         eng_data,
  output logic [$clog2(QDEPTH):0]   q_count,
  input  logic                      hist_rd,
  output logic                      hist_valid,
  output logic [TAG_W-1:0]          hist_tag,
  output logic [TS_W-1:0]           hist_stamp
);
  localparam int QW = TAG_W + DATA_W;
  localparam int HW = TAG_W + TS_W;

  txq_state_e              state_q;
  logic                    busy, armed_q;
  logic                    src_cont, no_retry, fail;
  logic                    launch, done_ok, aborted, dropped, retry;
  logic                    q_pop, q_push;
  logic [QW-1:0]           q_head;
  logic [HW-1:0]           h_head;
  logic [$clog2(HDEPTH):0] h_count;
  logic [TS_W-1:0]         stamp;

  assign busy     = (state_q == TXQ_WAIT);
  assign src_cont = pin_txen | cfg_cont;
  assign no_retry = cfg_oneshot & cfg_single;
  assign fail     = (eng_arb_lost | eng_error) & ~eng_done_ok;

  always_comb begin
    launch  = !busy && (q_count != '0) && !cmd_clear &&
              (src_cont || (cfg_single && armed_q));
    aborted = busy && !cmd_clear && cmd_abort;
    done_ok = busy && !cmd_clear && !cmd_abort && eng_done_ok;
    dropped = busy && !cmd_clear && !cmd_abort && fail && no_retry;
    retry   = busy && !cmd_clear && !cmd_abort && fail && !no_retry;
    q_pop   = done_ok | aborted | dropped;
    q_push  = wr_valid & ~cmd_clear;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= TXQ_IDLE;
      armed_q   <= 1'b1;
      eng_start <= 1'b0;
      eng_abort <= 1'b0;
    end else begin
      if (cmd_clear || q_pop) state_q <= TXQ_IDLE;
      else if (launch)        state_q <= TXQ_WAIT;
      eng_start <= launch | retry;
      eng_abort <= busy & (cmd_clear | cmd_abort);
      if (!cfg_single)              armed_q <= 1'b1;
      else if (launch && !src_cont) armed_q <= 1'b0;
    end
  end

  txq_fifo #(.W(QW), .DEPTH(QDEPTH)) u_msgq (
    .clk     (clk),
    .rst     (rst),
    .clr     (cmd_clear),
    .wr_en   (q_push),
    .wr_data ({wr_tag, wr_data}),
    .rd_en   (q_pop),
    .rd_data (q_head),
    .count   (q_count)
  );

  txq_fifo #(.W(HW), .DEPTH(HDEPTH)) u_hist (
    .clk     (clk),
    .rst     (rst),
    .clr     (1'b0),
    .wr_en   (done_ok),
    .wr_data ({q_head[QW-1 -: TAG_W], stamp}),
    .rd_en   (hist_rd),
    .rd_data (h_head),
    .count   (h_count)
  );

  txq_timetag #(.TS_W(TS_W)) u_tt (
    .clk    (clk),
    .rst    (rst),
    .tt_div (tt_div),
    .stamp  (stamp)
  );

  assign eng_tag    = q_head[QW-1 -: TAG_W];
  assign eng_data   = q_head[DATA_W-1:0];
  assign hist_valid = (h_count != '0);
  assign hist_tag   = h_head[HW-1 -: TAG_W];
  assign hist_stamp = h_head[TS_W-1:0];
endmodule

// File: rtl/txq_launch_chk.sv
module txq_launch_chk #(
  parameter int QDEPTH = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    busy,
  input logic                    pin_txen,
  input logic                    cfg_cont,
  input logic                    cfg_single,
  input logic                    cfg_oneshot,
  input logic                    cmd_clear,
  input logic                    cmd_abort,
  input logic                    eng_done_ok,
  input logic                    eng_arb_lost,
  input logic                    eng_error,
  input logic                    eng_start,
  input logic                    eng_abort,
  input logic                    hist_valid,
  input logic [$clog2(QDEPTH):0] q_count
);
  localparam int QCW = $clog2(QDEPTH) + 1;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    q_count <= QCW'(QDEPTH)); // R1

  AST_START_HAS_HEAD: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> q_count != '0); // R2

  AST_NO_SOURCE_NO_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (!busy && !pin_txen && !cfg_cont && !cfg_single) |=> !eng_start); // R5

  AST_ONESHOT_NO_RETRY: assert property (@(posedge clk) disable iff (rst)
    (busy && !cmd_clear && !cmd_abort && !eng_done_ok && (eng_arb_lost || eng_error)
     && cfg_oneshot && cfg_single) |=> (!eng_start && !busy)); // R6

  AST_RETRY_RELAUNCH: assert property (@(posedge clk) disable iff (rst)
    (busy && !cmd_clear && !cmd_abort && !eng_done_ok && (eng_arb_lost || eng_error)
     && !(cfg_oneshot && cfg_single)) |=> eng_start); // R7

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_abort) |=> (eng_abort && !busy)); // R8

  AST_ABORT_NO_HIST: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_abort && !hist_valid) |=> !hist_valid); // R8

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    cmd_clear |=> q_count == '0); // R9

  AST_OK_RECORDS: assert property (@(posedge clk) disable iff (rst)
    (busy && eng_done_ok && !cmd_clear && !cmd_abort) |=> hist_valid); // R10

  AST_IDLE_RESULT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busy && !pin_txen && !cfg_cont && !cfg_single && (eng_done_ok || eng_error))
     |=> !busy); // R13
endmodule

bind txq_launch_ctrl txq_launch_chk #(.QDEPTH(QDEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .pin_txen     (pin_txen),
  .cfg_cont     (cfg_cont),
  .cfg_single   (cfg_single),
  .cfg_oneshot  (cfg_oneshot),
  .cmd_clear    (cmd_clear),
  .cmd_abort    (cmd_abort),
  .eng_done_ok  (eng_done_ok),
  .eng_arb_lost (eng_arb_lost),
  .eng_error    (eng_error),
  .eng_start    (eng_start),
  .eng_abort    (eng_abort),
  .hist_valid   (hist_valid),
  .q_count      (q_count)
);

// File: tb/tb_txq_launch_ctrl.sv
module tb_txq_launch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 8, DATA_W = 64, QD = 8, HD = 8, TS_W = 16;
  localparam int QW = TAG_W + DATA_W;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_valid = 0, pin_txen = 0, cfg_cont = 0, cfg_single = 0, cfg_oneshot = 0;
  logic cmd_clear = 0, cmd_abort = 0, eng_done_ok = 0, eng_arb_lost = 0, eng_error = 0;
  logic hist_rd = 0;
  logic [TAG_W-1:0]  wr_tag = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0]        tt_div = 2'd0;
  logic eng_start, eng_abort, hist_valid;
  logic [TAG_W-1:0]  eng_tag, hist_tag;
  logic [DATA_W-1:0] eng_data;
  logic [TS_W-1:0]   hist_stamp;
  logic [$clog2(QD):0] q_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  txq_launch_ctrl dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_tag(wr_tag), .wr_data(wr_data),
    .pin_txen(pin_txen), .cfg_cont(cfg_cont), .cfg_single(cfg_single),
    .cfg_oneshot(cfg_oneshot), .cmd_clear(cmd_clear), .cmd_abort(cmd_abort),
    .tt_div(tt_div), .eng_done_ok(eng_done_ok), .eng_arb_lost(eng_arb_lost),
    .eng_error(eng_error), .eng_start(eng_start), .eng_abort(eng_abort),
    .eng_tag(eng_tag), .eng_data(eng_data), .q_count(q_count), .hist_rd(hist_rd),
    .hist_valid(hist_valid), .hist_tag(hist_tag), .hist_stamp(hist_stamp)
  );

  int checks = 0, fails = 0, cyc_n = 0;

  // behavioural reference model
  logic [QW-1:0]          mq[$];
  logic [TAG_W+TS_W-1:0]  mh[$];
  bit m_busy, m_start, m_abort, m_armed;
  int m_pre, m_stamp, qs, hs, mask;
  bit src, mfail, ns, na, pop;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); mh.delete();
      m_busy = 0; m_start = 0; m_abort = 0; m_armed = 1; m_pre = 0; m_stamp = 0;
    end else begin
      qs = mq.size(); hs = mh.size();
      src = pin_txen | cfg_cont;
      mfail = (eng_arb_lost | eng_error) & ~eng_done_ok;
      ns = 0; na = 0; pop = 0;
      if (cmd_clear) begin
        if (m_busy) na = 1;
        m_busy = 0;
        mq.delete();
      end else begin
        if (m_busy) begin
          if (cmd_abort) begin pop = 1; na = 1; m_busy = 0; end
          else if (eng_done_ok) begin
            pop = 1; m_busy = 0;
            if (hs < HD) mh.push_back({mq[0][QW-1 -: TAG_W], 16'(m_stamp)});
          end else if (mfail) begin
            if (cfg_oneshot && cfg_single) begin pop = 1; m_busy = 0; end
            else ns = 1;
          end
        end else if (qs > 0 && (src || (cfg_single && m_armed))) begin
          m_busy = 1; ns = 1;
          if (!src) m_armed = 0;
        end
        if (pop) void'(mq.pop_front());
        if (wr_valid && qs < QD) mq.push_back({wr_tag, wr_data});
      end
      if (!cfg_single) m_armed = 1;
      if (hist_rd && hs > 0) void'(mh.pop_front());
      mask = (1 << tt_div) - 1;
      if ((m_pre & mask) == mask) m_stamp = (m_stamp + 1) % 65536;
      m_pre = (m_pre + 1) % 8;
      m_start = ns; m_abort = na;
    end
  end

  task automatic check(input string req, input string nm, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, nm, act, exp);
    end
  endtask

  task automatic compare();
    check("R1", "q_count", 128'(q_count), 128'(mq.size()));
    check("R3", "eng_start", 128'(eng_start), 128'(m_start));
    check("R8", "eng_abort", 128'(eng_abort), 128'(m_abort));
    check("R10", "hist_valid", 128'(hist_valid), 128'(mh.size() != 0));
    if (m_start) check("R2", "head message", 128'({eng_tag, eng_data}), 128'(mq[0]));
    if (mh.size() != 0) check("R11", "history entry", 128'({hist_tag, hist_stamp}), 128'(mh[0]));
  endtask

  // engine responder: result three cycles after a start
  int rq[$];
  int resp_cnt = 0;
  int seq = 0;

  task automatic cyc();
    int m;
    @(negedge clk);
    compare();
    wr_valid = 0; cmd_clear = 0; cmd_abort = 0; hist_rd = 0;
    eng_done_ok = 0; eng_arb_lost = 0; eng_error = 0;
    if (eng_start) resp_cnt = 3;
    else if (resp_cnt > 0) begin
      resp_cnt--;
      if (resp_cnt == 0) begin
        m = (rq.size() != 0) ? rq.pop_front() : 0;
        case (m)
          0: eng_done_ok = 1;
          1: eng_arb_lost = 1;
          2: eng_error = 1;
          default: ;
        endcase
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic push_msg();
    wr_valid = 1; wr_tag = 8'(8'h10 + seq); wr_data = 64'(seq) * 64'h0101_0203_0405_0607;
    seq++;
    cyc();
  endtask

  task automatic drain_hist();
    while (hist_valid) begin hist_rd = 1; cyc(); end
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > WATCHDOG) begin
      fails++; checks++;
      $display("FAIL R12 watchdog: actual %0d cycles expected < %0d", cyc_n, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "reset q_count", 128'(q_count), 0);
    check("R12", "reset start/abort", 128'({eng_start, eng_abort}), 0);
    check("R12", "reset hist_valid", 128'(hist_valid), 0);
    rst = 0;

    // R5 queued messages stay with no source
    for (int i = 0; i < 3; i++) push_msg();
    run(10);
    check("R5", "queued without source", 128'(q_count), 3);

    // R13 results while idle
    eng_done_ok = 1; cyc(); eng_error = 1; cyc(); run(2);
    check("R13", "idle results ignored", 128'({q_count, hist_valid}), 128'({4'd3, 1'b0}));

    // R3 continuous drain
    cfg_cont = 1; run(30); cfg_cont = 0;
    check("R3", "continuous drained", 128'(q_count), 0);
    drain_hist();

    // R7 retry after arbitration loss and error, via pin
    rq = '{1, 2};
    push_msg(); push_msg();
    pin_txen = 1; run(40); pin_txen = 0;
    check("R7", "retried and sent", 128'(q_count), 0);
    drain_hist();

    // R4 single-message per rising edge
    for (int i = 0; i < 3; i++) push_msg();
    cfg_single = 1; run(20);
    check("R4", "one sent per edge", 128'(q_count), 2);
    cfg_single = 0; cyc(); cfg_single = 1; run(20);
    check("R4", "second edge sends one", 128'(q_count), 1);
    cfg_single = 0; cyc();

    // R6 one-shot drop on failure
    rq = '{2};
    cfg_oneshot = 1; cfg_single = 1; run(12);
    check("R6", "dropped without retry", 128'(q_count), 0);
    cfg_single = 0; cfg_oneshot = 0; cyc();
    drain_hist();

    // R8 abort in flight, then abort while idle
    rq = '{3};
    push_msg(); push_msg();
    cfg_cont = 1; run(3); cfg_cont = 0;
    cmd_abort = 1; cyc(); run(2);
    check("R8", "abort removed head", 128'({q_count, hist_valid}), 128'({4'd1, 1'b0}));
    cmd_abort = 1; cyc(); run(2);
    check("R8", "idle abort no effect", 128'(q_count), 1);
    resp_cnt = 0;

    // R9 clear in flight with same-cycle write
    rq = '{3};
    push_msg(); push_msg();
    cfg_cont = 1; run(3);
    cmd_clear = 1; wr_valid = 1; wr_tag = 8'hEE; cyc(); run(3);
    check("R9", "clear empties", 128'(q_count), 0);
    cfg_cont = 0; resp_cnt = 0; rq.delete(); run(2);

    // R1 overflow ignored
    for (int i = 0; i < 11; i++) push_msg();
    check("R1", "full queue", 128'(q_count), QD);

    // R10/R11 history overflow with slower time stamp clocks
    tt_div = 2'd2; cfg_cont = 1; run(20); tt_div = 2'd3; run(20); tt_div = 2'd1;
    for (int i = 0; i < 3; i++) push_msg();
    run(30); cfg_cont = 0; run(2);
    check("R10", "history holds depth", 128'(hist_valid), 1);
    drain_hist();
    check("R10", "history drained", 128'(hist_valid), 0);
    tt_div = 2'd0; run(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule